// File: doc/BRIEF.md
# Interrupt controller command interface

This block is the byte-wide programming port of one eight-line priority interrupt controller. A host writes and reads it through one address bit, a write strobe, a read strobe and an 8-bit data bus. A separate select input steers an access to the trigger-mode register instead. The block runs the multi-word initialization sequence, in which the fourth word is optional. It decodes the two families of operation commands: end-of-interrupt and priority commands, and mode commands for poll, register-read select and special mask. It holds the mask, in-service, base-vector, priority-offset and mode state that a separate resolver reads.

The request register and the acknowledge logic live in the resolver. They reach this block as the `req_vec` input and the `isr_set` input. A poll read acts as an acknowledge. It returns the winning line and pulses `req_clr`, so the resolver can clear that request. Register updates happen on the clock edge while `wr_en` or `rd_en` is high. Read data is combinational while `rd_en` is high.

Top module: `intc_cmd_port`

## Requirements
- R1: A write to address 0 with data bit 4 set clears the mask, in-service, priority offset, base vector, auto-EOI, nested-mode, rotate-on-auto-EOI, special-mask, read-select and poll state, and raises `init_active`.
- R2: After that command word, the next address-1 write loads the base vector with data AND 0xF8. The following address-1 write is accepted and has no effect. If bit 0 of the command word was clear, that write also ends the sequence and drops `init_active`.
- R3: If bit 0 of the command word was set, a further address-1 write is taken as the mode word. Its bit 4 loads `nested_mode` and its bit 1 loads `auto_eoi`, and the sequence then ends.
- R4: Outside the init sequence, an address-1 write loads the mask. A non-poll read at address 1 returns the mask.
- R5: An address-0 write with bit 3 set and bit 4 clear is a mode command. If bit 1 is set, bit 0 picks the register that address-0 reads return: 1 for in-service, 0 for `req_vec`. If bit 6 is set, bit 5 loads `special_mask`. If bit 2 is set, poll is armed.
- R6: An address-0 write with bits 4 and 3 clear is a command in bits 7:5. Code 0 clears `rot_on_aeoi`, code 4 sets it, and code 2 changes nothing.
- R7: Codes 1 and 5 clear the in-service bit of highest priority. Priority runs from line `prio_off` upward, modulo 8. Code 5 then sets `prio_off` to that line plus 1, modulo 8. With no bit in service, neither code changes anything.
- R8: Code 3 clears the in-service bit named by data bits 2:0. Code 7 does the same and sets `prio_off` to that line plus 1. Code 6 sets `prio_off` to bits 2:0 plus 1, all modulo 8.
- R9: A read while poll is armed returns the line number of the highest-priority unmasked request if that request outranks every in-service line. The read then pulses that line in `req_clr` and clears its in-service bit. Otherwise the read returns 7 and pulses nothing. Every read at address 0 or 1 disarms poll.
- R10: A write with `trig_sel` high loads the trigger-mode register with data AND the writable-bit parameter, 0xF8 by default. A read with `trig_sel` high returns that register. An init command word leaves it unchanged.
- R11: Each bit set in `isr_set` sets the matching in-service bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 1 | Register address bit |
| trig_sel | input | 1 | Steers the access to the trigger-mode register |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| req_vec | input | 8 | Request lines from the resolver |
| isr_set | input | 8 | In-service set pulses from the resolver |
| req_clr | output | 8 | Request clear pulse on a successful poll read |
| mask_q | output | 8 | Mask register |
| isr_q | output | 8 | In-service register |
| base_vec | output | 8 | Base vector, low three bits zero |
| prio_off | output | 3 | Line holding the top priority |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| rot_on_aeoi | output | 1 | Rotate on auto end-of-interrupt |
| nested_mode | output | 1 | Special fully nested mode |
| special_mask | output | 1 | Special mask mode |
| init_active | output | 1 | Init sequence in progress |

## Verification
The embedded properties assume that a write and a read never share a cycle, and that each strobe stands for a single access. The one-bit-per-end-of-interrupt property also assumes that `isr_set` is quiet during the command cycle. The bench drives each strobe for exactly one cycle from a task and never overlaps reads and writes. It pulses `isr_set` only in cycles of its own with no access.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;
   typedef enum logic [1:0] {
      INIT_IDLE = 2'd0,
      INIT_BASE = 2'd1,
      INIT_SKIP = 2'd2,
      INIT_MODE = 2'd3
   } init_st_e;

   localparam logic [2:0] OP_ROT_CLR  = 3'd0;
   localparam logic [2:0] OP_EOI      = 3'd1;
   localparam logic [2:0] OP_NOP      = 3'd2;
   localparam logic [2:0] OP_SPEC_EOI = 3'd3;
   localparam logic [2:0] OP_ROT_SET  = 3'd4;
   localparam logic [2:0] OP_EOI_ROT  = 3'd5;
   localparam logic [2:0] OP_SET_PRIO = 3'd6;
   localparam logic [2:0] OP_SPEC_ROT = 3'd7;
endpackage

// File: rtl/intc_prio_rank.sv
module intc_prio_rank #(
   parameter int LINES  = 8,
   localparam int IDX_W  = $clog2(LINES),
   localparam int RANK_W = IDX_W + 1
) (
   input  logic [LINES-1:0] vec,
   input  logic [IDX_W-1:0] off,
   output logic [RANK_W-1:0] rank,
   output logic [IDX_W-1:0] line
);
   always_comb begin
      rank = RANK_W'(LINES);
      line = '0;
      for (int k = LINES - 1; k >= 0; k--) begin
         logic [IDX_W-1:0] idx;
         idx = off + IDX_W'(k);
         if (vec[idx]) begin
            rank = RANK_W'(k);
            line = idx;
         end
      end
   end
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
   import intc_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              icw1,
   input  logic              wr1,
   input  logic [DATA_W-1:0] wdata,
   output logic              mask_load,
   output logic              init_active,
   output logic [DATA_W-1:0] base_vec,
   output logic              auto_eoi,
   output logic              nested_mode
);
   localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'(LINES - 1);

   init_st_e st_q;
   logic     four_q;

   assign init_active = (st_q != INIT_IDLE);
   assign mask_load   = wr1 && (st_q == INIT_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= INIT_IDLE;
         four_q      <= 1'b0;
         base_vec    <= '0;
         auto_eoi    <= 1'b0;
         nested_mode <= 1'b0;
      end else if (icw1) begin
         st_q        <= INIT_BASE;
         four_q      <= wdata[0];
         base_vec    <= '0;
         auto_eoi    <= 1'b0;
         nested_mode <= 1'b0;
      end else if (wr1) begin
         unique case (st_q)
            INIT_BASE: begin
               base_vec <= wdata & BASE_KEEP;
               st_q     <= INIT_SKIP;
            end
            INIT_SKIP: st_q <= four_q ? INIT_MODE : INIT_IDLE;
            INIT_MODE: begin
               nested_mode <= wdata[4];
               auto_eoi    <= wdata[1];
               st_q        <= INIT_IDLE;
            end
            default: st_q <= INIT_IDLE;
         endcase
      end
   end

   p_skip_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && !icw1 && st_q == INIT_SKIP && !four_q) |=> (st_q == INIT_IDLE));
   p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!icw1 && !(wr1 && st_q == INIT_BASE)) |=> $stable(base_vec));
endmodule

// File: rtl/intc_isr_ctl.sv
module intc_isr_ctl
   import intc_cmd_pkg::*;
#(
   parameter int LINES = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             icw1,
   input  logic             ocw2,
   input  logic [2:0]       op,
   input  logic [IDX_W-1:0] lvl,
   input  logic             top_found,
   input  logic [IDX_W-1:0] top_line,
   input  logic [LINES-1:0] isr_set,
   input  logic [LINES-1:0] poll_clr,
   output logic [LINES-1:0] isr_q,
   output logic [IDX_W-1:0] off_q,
   output logic             rot_q
);
   logic [LINES-1:0] clr;
   logic [IDX_W-1:0] off_d;
   logic             off_we, rot_d;

   always_comb begin
      clr    = poll_clr;
      off_d  = off_q;
      off_we = 1'b0;
      rot_d  = rot_q;
      if (ocw2) begin
         unique case (op)
            OP_ROT_CLR: rot_d = 1'b0;
            OP_ROT_SET: rot_d = 1'b1;
            OP_EOI: if (top_found) clr[top_line] = 1'b1;
            OP_EOI_ROT: if (top_found) begin
               clr[top_line] = 1'b1;
               off_d  = top_line + 1'b1;
               off_we = 1'b1;
            end
            OP_SPEC_EOI: clr[lvl] = 1'b1;
            OP_SET_PRIO: begin
               off_d  = lvl + 1'b1;
               off_we = 1'b1;
            end
            OP_SPEC_ROT: begin
               clr[lvl] = 1'b1;
               off_d  = lvl + 1'b1;
               off_we = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
         off_q <= '0;
         rot_q <= 1'b0;
      end else if (icw1) begin
         isr_q <= '0;
         off_q <= '0;
         rot_q <= 1'b0;
      end else begin
         isr_q <= (isr_q & ~clr) | isr_set;
         rot_q <= rot_d;
         if (off_we) off_q <= off_d;
      end
   end

   p_eoi_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2 && (op == OP_EOI || op == OP_EOI_ROT) && isr_q != '0
       && isr_set == '0 && poll_clr == '0)
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
   p_isr_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!icw1 && isr_set != '0) |=> ((isr_q & $past(isr_set)) == $past(isr_set)));
endmodule

// File: rtl/intc_trig_reg.sv
module intc_trig_reg #(
   parameter int              DATA_W   = 8,
   parameter logic [DATA_W-1:0] WR_MASK = 8'hF8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] trig_q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (WR_MASK[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  trig_q[i] <= 1'b0;
            else if (we) trig_q[i] <= wdata[i];
         end
      end else begin : g_tie
         assign trig_q[i] = 1'b0;
      end
   end

   p_trig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(trig_q));
endmodule

// File: rtl/intc_cmd_port.sv
module intc_cmd_port
   import intc_cmd_pkg::*;
#(
   parameter int                LINES     = 8,
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] TRIG_MASK = 8'hF8,
   localparam int IDX_W  = $clog2(LINES),
   localparam int RANK_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic              trig_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic [LINES-1:0]  req_vec,
   input  logic [LINES-1:0]  isr_set,
   output logic [LINES-1:0]  req_clr,
   output logic [LINES-1:0]  mask_q,
   output logic [LINES-1:0]  isr_q,
   output logic [DATA_W-1:0] base_vec,
   output logic [IDX_W-1:0]  prio_off,
   output logic              auto_eoi,
   output logic              rot_on_aeoi,
   output logic              nested_mode,
   output logic              special_mask,
   output logic              init_active
);
   if (DATA_W != 8) begin : g_bad_width
      $error("intc_cmd_port: command fields need an 8-bit bus");
   end
   if (LINES != 8) begin : g_bad_lines
      $error("intc_cmd_port: line fields need exactly eight lines");
   end

   logic wr0, wr1, icw1, ocw2, ocw3, mask_load, poll_q, rdsel_q, poll_rd;
   logic [RANK_W-1:0] isr_rank, pend_rank;
   logic [IDX_W-1:0]  isr_line, pend_line;
   logic [DATA_W-1:0] trig_q;
   logic              poll_hit;

   assign wr0  = wr_en && !addr && !trig_sel;
   assign wr1  = wr_en &&  addr && !trig_sel;
   assign icw1 = wr0 &&  wdata[4];
   assign ocw3 = wr0 && !wdata[4] &&  wdata[3];
   assign ocw2 = wr0 && !wdata[4] && !wdata[3];

   intc_init_seq #(.DATA_W(DATA_W), .LINES(LINES)) u_init (
      .clk(clk), .rst_n(rst_n), .icw1(icw1), .wr1(wr1), .wdata(wdata),
      .mask_load(mask_load), .init_active(init_active), .base_vec(base_vec),
      .auto_eoi(auto_eoi), .nested_mode(nested_mode));

   intc_prio_rank #(.LINES(LINES)) u_isr_rank (
      .vec(isr_q), .off(prio_off), .rank(isr_rank), .line(isr_line));

   intc_prio_rank #(.LINES(LINES)) u_pend_rank (
      .vec(req_vec & ~mask_q), .off(prio_off), .rank(pend_rank), .line(pend_line));

   assign poll_rd  = rd_en && !trig_sel && poll_q;
   assign poll_hit = (pend_rank < isr_rank);

   always_comb begin
      req_clr = '0;
      if (poll_rd && poll_hit) req_clr[pend_line] = 1'b1;
   end

   intc_isr_ctl #(.LINES(LINES)) u_isr (
      .clk(clk), .rst_n(rst_n), .icw1(icw1), .ocw2(ocw2), .op(wdata[7:5]),
      .lvl(wdata[IDX_W-1:0]), .top_found(isr_rank != RANK_W'(LINES)),
      .top_line(isr_line), .isr_set(isr_set), .poll_clr(req_clr),
      .isr_q(isr_q), .off_q(prio_off), .rot_q(rot_on_aeoi));

   intc_trig_reg #(.DATA_W(DATA_W), .WR_MASK(TRIG_MASK)) u_trig (
      .clk(clk), .rst_n(rst_n), .we(wr_en && trig_sel), .wdata(wdata),
      .trig_q(trig_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q       <= '0;
         poll_q       <= 1'b0;
         rdsel_q      <= 1'b0;
         special_mask <= 1'b0;
      end else if (icw1) begin
         mask_q       <= '0;
         poll_q       <= 1'b0;
         rdsel_q      <= 1'b0;
         special_mask <= 1'b0;
      end else begin
         if (mask_load) mask_q <= wdata[LINES-1:0];
         if (rd_en && !trig_sel) poll_q <= 1'b0;
         if (ocw3) begin
            if (wdata[2]) poll_q       <= 1'b1;
            if (wdata[1]) rdsel_q      <= wdata[0];
            if (wdata[6]) special_mask <= wdata[5];
         end
      end
   end

   always_comb begin
      if (trig_sel)
         rd_data = trig_q;
      else if (poll_q)
         rd_data = poll_hit ? DATA_W'(pend_line) : DATA_W'(LINES - 1);
      else if (addr)
         rd_data = DATA_W'(mask_q);
      else
         rd_data = rdsel_q ? DATA_W'(isr_q) : DATA_W'(req_vec);
   end

   p_no_rdwr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
   p_init_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      icw1 |=> (init_active && mask_q == '0 && isr_q == '0 && prio_off == '0));
   p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!icw1 && !mask_load) |=> $stable(mask_q));
   p_poll_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !trig_sel) |=> !poll_q);
   p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_clr));
endmodule

// File: tb/intc_cmd_port_bench.sv
`timescale 1ns/1ps
module intc_cmd_port_bench;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       wr_en = 0, rd_en = 0, addr = 0, trig_sel = 0;
   logic [7:0] wdata = '0, req_vec = '0, isr_set = '0;
   logic [7:0] rd_data, req_clr, mask_q, isr_q, base_vec;
   logic [2:0] prio_off;
   logic       auto_eoi, rot_on_aeoi, nested_mode, special_mask, init_active;
   int         errs = 0, checks = 0;
   logic       done = 0;

   always #2.5 clk = ~clk;

   intc_cmd_port u_intc_cmd_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .trig_sel(trig_sel), .wdata(wdata), .rd_data(rd_data), .req_vec(req_vec),
      .isr_set(isr_set), .req_clr(req_clr), .mask_q(mask_q), .isr_q(isr_q),
      .base_vec(base_vec), .prio_off(prio_off), .auto_eoi(auto_eoi),
      .rot_on_aeoi(rot_on_aeoi), .nested_mode(nested_mode),
      .special_mask(special_mask), .init_active(init_active));

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic a, logic [7:0] d, logic t = 1'b0);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d; trig_sel = t;
      @(negedge clk);
      wr_en = 0; trig_sel = 0;
   endtask

   task automatic rd(logic a, output logic [7:0] d, output logic [7:0] c, input logic t = 1'b0);
      @(negedge clk);
      rd_en = 1; addr = a; trig_sel = t;
      #1 d = rd_data; c = req_clr;
      @(negedge clk);
      rd_en = 0; trig_sel = 0;
   endtask

   task automatic pulse_isr(logic [7:0] v);
      @(negedge clk);
      isr_set = v;
      @(negedge clk);
      isr_set = '0;
   endtask

   task automatic t_reset;
      logic [7:0] d, c;
      chk("R1 reset mask", mask_q, 8'h00);
      chk("R1 reset isr", isr_q, 8'h00);
      chk("R1 reset init", {7'd0, init_active}, 8'h00);
      rd(1'b1, d, c);
      chk("R4 reset mask read", d, 8'h00);
   endtask

   task automatic t_init_four;
      logic [7:0] d, c;
      wr(1'b1, 8'h33);
      wr(1'b0, 8'h11);
      chk("R1 init active", {7'd0, init_active}, 8'h01);
      chk("R1 mask cleared", mask_q, 8'h00);
      wr(1'b1, 8'h2D);
      chk("R2 base vector", base_vec, 8'h28);
      wr(1'b1, 8'hFF);
      chk("R2 third word ignored", mask_q, 8'h00);
      chk("R3 still in init", {7'd0, init_active}, 8'h01);
      wr(1'b1, 8'h12);
      chk("R3 nested mode", {7'd0, nested_mode}, 8'h01);
      chk("R3 auto eoi", {7'd0, auto_eoi}, 8'h01);
      chk("R3 init done", {7'd0, init_active}, 8'h00);
      wr(1'b1, 8'hA5);
      rd(1'b1, d, c);
      chk("R4 mask load", d, 8'hA5);
   endtask

   task automatic t_init_three;
      logic [7:0] d, c;
      wr(1'b0, 8'h10);
      chk("R1 mode bits cleared", {6'd0, nested_mode, auto_eoi}, 8'h00);
      wr(1'b1, 8'h47);
      chk("R2 base masked", base_vec, 8'h40);
      wr(1'b1, 8'h00);
      chk("R2 ends without fourth", {7'd0, init_active}, 8'h00);
      wr(1'b1, 8'h3C);
      rd(1'b1, d, c);
      chk("R4 mask after short init", d, 8'h3C);
   endtask

   task automatic t_mode_cmd;
      logic [7:0] d, c;
      req_vec = 8'h5A;
      wr(1'b0, 8'h0A);
      rd(1'b0, d, c);
      chk("R5 read request", d, 8'h5A);
      pulse_isr(8'h81);
      chk("R11 isr set", isr_q, 8'h81);
      wr(1'b0, 8'h0B);
      rd(1'b0, d, c);
      chk("R5 read in-service", d, 8'h81);
      wr(1'b0, 8'h08);
      rd(1'b0, d, c);
      chk("R5 select kept", d, 8'h81);
      wr(1'b0, 8'h68);
      chk("R5 special mask on", {7'd0, special_mask}, 8'h01);
      wr(1'b0, 8'h28);
      chk("R5 special mask kept", {7'd0, special_mask}, 8'h01);
      wr(1'b0, 8'h48);
      chk("R5 special mask off", {7'd0, special_mask}, 8'h00);
   endtask

   task automatic t_rotate_flag;
      wr(1'b0, 8'h80);
      chk("R6 rotate set", {7'd0, rot_on_aeoi}, 8'h01);
      wr(1'b0, 8'h00);
      chk("R6 rotate clear", {7'd0, rot_on_aeoi}, 8'h00);
   endtask

   task automatic t_eoi;
      wr(1'b0, 8'h20);
      chk("R7 plain eoi", isr_q, 8'h80);
      pulse_isr(8'h14);
      wr(1'b0, 8'hC3);
      chk("R8 set priority", {5'd0, prio_off}, 8'h04);
      wr(1'b0, 8'hA0);
      chk("R7 rotating eoi isr", isr_q, 8'h84);
      chk("R7 rotating eoi offset", {5'd0, prio_off}, 8'h05);
      wr(1'b0, 8'h20);
      chk("R7 rotated order", isr_q, 8'h04);
      chk("R7 offset kept", {5'd0, prio_off}, 8'h05);
      wr(1'b0, 8'h40);
      chk("R6 no-op isr", isr_q, 8'h04);
      chk("R6 no-op offset", {5'd0, prio_off}, 8'h05);
      wr(1'b0, 8'h62);
      chk("R8 specific eoi", isr_q, 8'h00);
      wr(1'b0, 8'hA0);
      chk("R7 empty eoi offset", {5'd0, prio_off}, 8'h05);
      pulse_isr(8'h40);
      wr(1'b0, 8'hE6);
      chk("R8 specific rotate isr", isr_q, 8'h00);
      chk("R8 specific rotate offset", {5'd0, prio_off}, 8'h07);
   endtask

   task automatic t_poll;
      logic [7:0] d, c;
      wr(1'b0, 8'hC7);
      chk("R8 offset wraps", {5'd0, prio_off}, 8'h00);
      wr(1'b1, 8'h01);
      req_vec = 8'h0A;
      wr(1'b0, 8'h0C);
      rd(1'b0, d, c);
      chk("R9 poll winner", d, 8'h01);
      chk("R9 poll clear", c, 8'h02);
      rd(1'b0, d, c);
      chk("R9 poll disarmed", d, 8'h00);
      chk("R9 no clear after", c, 8'h00);
      pulse_isr(8'h01);
      wr(1'b0, 8'h0C);
      rd(1'b1, d, c);
      chk("R9 outranked returns 7", d, 8'h07);
      chk("R9 outranked no clear", c, 8'h00);
      rd(1'b1, d, c);
      chk("R9 disarmed at addr 1", d, 8'h01);
   endtask

   task automatic t_trig;
      logic [7:0] d, c;
      wr(1'b0, 8'hFF, 1'b1);
      rd(1'b0, d, c, 1'b1);
      chk("R10 writable bits", d, 8'hF8);
      wr(1'b0, 8'hAA, 1'b1);
      wr(1'b0, 8'h10);
      rd(1'b0, d, c, 1'b1);
      chk("R10 kept across init", d, 8'hA8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_init_four();
      t_init_three();
      t_mode_cmd();
      t_rotate_flag();
      t_eoi();
      t_poll();
      t_trig();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errs++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule